// File: doc/BRIEF.md
# Write-Only Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock plus bidirectional data, I2C-style) that only accepts writes. It oversamples both bus lines with the system clock and detects bus conditions and clock edges from the synchronised copies. After a start condition it collects an address byte. The slave claims the transfer only when that byte names this device and requests a write. It then takes two data bytes and acknowledges each one. The 16 received bits become one register write, with a 7-bit register index and a 9-bit value. The block signals the write with a single-cycle strobe.

The device address is a 6-bit base, a parameter that defaults to binary 001101, followed by one low bit taken from the `addr_sel` pin. The block never answers a read. It drives the data line only through an open-drain enable, `sda_pull`, and a 1 on that output means the line is pulled low. The chip pad logic combines this enable with the bus to produce `sda_in`.

Top module: `twowire_wr_slave`

## Requirements
- R1: Nothing is received or acknowledged until a start condition occurs: data falling while clock is high. Bits clocked in while idle are ignored.
- R2: After a start, the 8 bits sampled on clock rising edges, MSB first, form the address byte. The byte is accepted when it equals {6'b001101, addr_sel, 1'b0}, so 8'h34 with `addr_sel`=0 and 8'h36 with `addr_sel`=1.
- R3: An address byte that does not match, or that has bit 0 (direction) set to 1, gets no acknowledge and no write. The slave stays idle until the next start.
- R4: An acknowledge asserts `sda_pull`=1 after the clock falls at the end of bit 8 and holds it through bit 9. It is released after the clock falls at the end of bit 9. `sda_pull` changes only while the synchronised clock is low.
- R5: After an accepted address, two data bytes are each acknowledged. The 16-bit word is formed as {first byte, second byte}. `wr_reg` receives word[15:9] and `wr_data` receives word[8:0].
- R6: `wr_pulse` is high for exactly one cycle, after the acknowledge of the second data byte ends. `wr_reg` and `wr_data` change only together with `wr_pulse`.
- R7: Bytes after the second data byte and before a stop are not acknowledged and produce no further write.
- R8: A stop condition (data rising while clock is high) ends any transfer. A frame stopped before its second data byte completes produces no write.
- R9: A start seen in the middle of a frame abandons it and restarts address reception.
- R10: While reset is asserted, and right after it is released, `sda_pull`=0, `wr_pulse`=0, `wr_reg`=0 and `wr_data`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Selects the least significant device address bit |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull the data line low (open-drain enable) |
| wr_pulse | output | 1 | One-cycle register write strobe |
| wr_reg | output | 7 | Register index of the last write |
| wr_data | output | 9 | Value of the last write |

## Verification
A table of transfers checks the address byte in several forms: correct for each level of `addr_sel`, correct for the other pin level, the read direction, and a mismatch in the top bit. This separates real address comparison from a check of only some bits or only the direction. Data words with mixed, all-ones and near-zero values show whether the 7/9 split sits at the right bit. Directed sequences cover a third byte, a stop after one data byte, a repeated start in the middle of a frame, and bits clocked with no start. These show whether the frame tracking aborts and ignores input as it should.

// File: rtl/twowire_pkg.sv
package twowire_pkg;

  localparam int TW_BYTE_W = 8;
  localparam int TW_REG_W  = 7;
  localparam int TW_DATA_W = 9;
  localparam int TW_WORD_W = TW_REG_W + TW_DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_DRAIN
  } tw_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_HI,
    PH_LO
  } tw_phase_e;

  typedef struct packed {
    logic [TW_REG_W-1:0]  reg_idx;
    logic [TW_DATA_W-1:0] value;
  } tw_word_t;

  // Expected address byte: base, select pin, write direction (0).
  function automatic logic [TW_BYTE_W-1:0] own_addr_byte(input logic [5:0] base,
                                                         input logic sel);
    return {base, sel, 1'b0};
  endfunction

  function automatic logic addr_accept(input logic [TW_BYTE_W-1:0] rx,
                                       input logic [5:0] base,
                                       input logic sel);
    return rx == own_addr_byte(base, sel);
  endfunction

  // Upper bits carry the register index, lower bits the value.
  function automatic tw_word_t split_word(input logic [TW_WORD_W-1:0] w);
    return tw_word_t'(w);
  endfunction

endpackage

// File: rtl/twowire_sync.sv
module twowire_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/twowire_cond_det.sv
module twowire_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twowire_frame_fsm.sv
module twowire_frame_fsm
  import twowire_pkg::*;
#(
  parameter logic [5:0] ADDR_BASE = 6'b001101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_sel,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  output logic                 sda_pull,
  output logic                 wr_pulse,
  output logic [TW_REG_W-1:0]  wr_reg,
  output logic [TW_DATA_W-1:0] wr_data,
  output logic                 byte_done,
  output logic                 addr_hit
);
  localparam int CNT_W = $clog2(TW_BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TW_BYTE_W - 1);

  tw_state_e              state;
  tw_phase_e              phase;
  logic [CNT_W-1:0]       bit_cnt;
  logic [TW_BYTE_W-1:0]   shreg, hi_q;
  logic [TW_BYTE_W-1:0]   rx_next;
  tw_word_t               word;

  assign rx_next   = {shreg[TW_BYTE_W-2:0], sda_s};
  assign byte_done = (state == ST_SHIFT) && scl_rise && (bit_cnt == LAST_BIT);
  assign addr_hit  = addr_accept(rx_next, ADDR_BASE, addr_sel);
  assign word      = split_word({hi_q, shreg});
  assign sda_pull  = (state == ST_ACK_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bit_cnt  <= '0;
      shreg    <= '0;
      hi_q     <= '0;
      wr_pulse <= 1'b0;
      wr_reg   <= '0;
      wr_data  <= '0;
    end else begin
      wr_pulse <= 1'b0;
      if (start_det) begin
        state   <= ST_SHIFT;
        phase   <= PH_ADDR;
        bit_cnt <= '0;
      end else if (stop_det) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_SHIFT: if (scl_rise) begin
            shreg   <= rx_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_done) begin
              unique case (phase)
                PH_ADDR: state <= addr_hit ? ST_ACK_SETUP : ST_IDLE;
                PH_HI: begin
                  hi_q  <= rx_next;
                  state <= ST_ACK_SETUP;
                end
                default: state <= ST_ACK_SETUP;
              endcase
            end
          end
          ST_ACK_SETUP: if (scl_fall) state <= ST_ACK_HOLD;
          ST_ACK_HOLD: if (scl_fall) begin
            if (phase == PH_LO) begin
              wr_pulse <= 1'b1;
              wr_reg   <= word.reg_idx;
              wr_data  <= word.value;
              state    <= ST_DRAIN;
            end else begin
              phase   <= (phase == PH_ADDR) ? PH_HI : PH_LO;
              bit_cnt <= '0;
              state   <= ST_SHIFT;
            end
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/twowire_wr_slave.sv
module twowire_wr_slave
  import twowire_pkg::*;
#(
  parameter logic [5:0] ADDR_BASE   = 6'b001101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_sel,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 sda_pull,
  output logic                 wr_pulse,
  output logic [TW_REG_W-1:0]  wr_reg,
  output logic [TW_DATA_W-1:0] wr_data
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, addr_hit;

  twowire_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     ({scl_s, sda_s})
  );

  twowire_cond_det u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twowire_frame_fsm #(.ADDR_BASE(ADDR_BASE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_sel  (addr_sel),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .wr_pulse  (wr_pulse),
    .wr_reg    (wr_reg),
    .wr_data   (wr_data),
    .byte_done (byte_done),
    .addr_hit  (addr_hit)
  );
endmodule

// File: rtl/twowire_wr_slave_chk.sv
module twowire_wr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_pull,
  input logic       wr_pulse,
  input logic [6:0] wr_reg,
  input logic [8:0] wr_data
);
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  a_r6_outputs_move_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wr_reg) || !$stable(wr_data)) |-> wr_pulse);

  a_r4_pull_changes_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_s);

  a_r5_write_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_pulse) |-> $past(sda_pull));

  a_r9_start_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_pull && !wr_pulse));

  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && !wr_pulse));
endmodule

bind twowire_wr_slave twowire_wr_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_pull  (sda_pull),
  .wr_pulse  (wr_pulse),
  .wr_reg    (wr_reg),
  .wr_data   (wr_data)
);

// File: tb/tb_twowire_wr_slave.sv
`timescale 1ns/1ps
module tb_twowire_wr_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, wr_pulse;
  logic [6:0] wr_reg;
  logic [8:0] wr_data;
  logic sda_bus;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  int pulse_cycles = 0;
  logic [6:0] exp_reg = '0;
  logic [8:0] exp_data = '0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  twowire_wr_slave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_sel (addr_sel),
    .scl_in   (scl_m),
    .sda_in   (sda_bus),
    .sda_pull (sda_pull),
    .wr_pulse (wr_pulse),
    .wr_reg   (wr_reg),
    .wr_data  (wr_data)
  );

  always @(posedge clk) begin
    if (wr_pulse) pulse_cycles++;
    if (wr_pulse && !$past(wr_pulse)) pulses++;
  end

  // sel, address byte, first data byte, second data byte, expected ack
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 8'h34, 8'hA5, 8'h3C, 1'b1},
    {1'b1, 8'h36, 8'h0F, 8'hF1, 1'b1},
    {1'b0, 8'h36, 8'h11, 8'h22, 1'b0},
    {1'b1, 8'h34, 8'h33, 8'h44, 1'b0},
    {1'b0, 8'h35, 8'h55, 8'h66, 1'b0},
    {1'b0, 8'hB4, 8'h77, 8'h88, 1'b0},
    {1'b1, 8'h36, 8'hFF, 8'hFF, 1'b1},
    {1'b0, 8'h34, 8'h00, 8'h01, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    check({req, " ack"}, {31'd0, sda_pull}, {31'd0, exp_ack});
    wq(Q);
    scl_m = 1'b0; wq(Q);
    check("R4 release after bit 9", {31'd0, sda_pull}, 32'd0);
  endtask

  task automatic check_write(input string req, input int base_pulses, input int n);
    wq(Q);
    check({req, " pulse count"}, pulses - base_pulses, n);
    check({req, " reg"}, {25'd0, wr_reg}, {25'd0, exp_reg});
    check({req, " data"}, {23'd0, wr_data}, {23'd0, exp_data});
  endtask

  initial begin
    int p0;
    logic [15:0] w;
    wq(5);
    check("R10 reset pull", {31'd0, sda_pull}, 32'd0);
    check("R10 reset pulse", {31'd0, wr_pulse}, 32'd0);
    rst_n = 1'b1;
    wq(2);
    check("R10 reset reg", {25'd0, wr_reg}, 32'd0);
    check("R10 reset data", {23'd0, wr_data}, 32'd0);

    foreach (VEC[k]) begin
      addr_sel = VEC[k][25];
      p0 = pulses;
      bus_start();
      send_byte(VEC[k][24:17], VEC[k][0], "R2 R3 address");
      send_byte(VEC[k][16:9], VEC[k][0], "R5 first byte");
      send_byte(VEC[k][8:1], VEC[k][0], "R5 second byte");
      bus_stop();
      if (VEC[k][0]) begin
        w = {VEC[k][16:9], VEC[k][8:1]};
        exp_reg = w[15:9];
        exp_data = w[8:0];
      end
      check_write(VEC[k][0] ? "R5 R6 write" : "R3 no write", p0, VEC[k][0] ? 1 : 0);
    end

    // R7: third data byte ignored
    addr_sel = 1'b0; p0 = pulses;
    bus_start();
    send_byte(8'h34, 1'b1, "R7 address");
    send_byte(8'h12, 1'b1, "R7 first");
    send_byte(8'h34, 1'b1, "R7 second");
    send_byte(8'h56, 1'b0, "R7 third");
    bus_stop();
    exp_reg = 7'h09; exp_data = 9'h034;
    check_write("R7", p0, 1);

    // R8: stop after first data byte
    p0 = pulses;
    bus_start();
    send_byte(8'h34, 1'b1, "R8 address");
    send_byte(8'h77, 1'b1, "R8 first");
    bus_stop();
    check_write("R8 aborted", p0, 0);

    // R1: bits clocked without a start
    p0 = pulses;
    scl_m = 1'b0; wq(Q);
    send_byte(8'h34, 1'b0, "R1 no start");
    send_byte(8'h40, 1'b0, "R1 no start data");
    send_byte(8'h02, 1'b0, "R1 no start data");
    bus_stop();
    check_write("R1 idle", p0, 0);

    // R9: repeated start mid-frame
    p0 = pulses;
    bus_start();
    send_byte(8'h34, 1'b1, "R9 address");
    send_byte(8'h99, 1'b1, "R9 first");
    bus_start();
    send_byte(8'h34, 1'b1, "R9 restarted address");
    send_byte(8'h44, 1'b1, "R9 first");
    send_byte(8'h21, 1'b1, "R9 second");
    bus_stop();
    exp_reg = 7'h22; exp_data = 9'h021;
    check_write("R9", p0, 1);

    check("R6 pulse width", pulse_cycles, pulses);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule